// File: doc/BRIEF.md
# Host-to-Controller Mailbox

This block sits between a simple host register port and an embedded control processor. The host sees a 16-byte register window. A byte written at any offset in that window is queued, tagged with its 4-bit offset, in a 16-entry FIFO. The controller empties that FIFO at its own pace through a show-ahead head and a pop strobe.

The return path is a single mailbox. The controller posts one data byte together with a 3-bit type code. Posting raises an active-low host interrupt. The host reads the byte at offset 0, and that read clears the interrupt. Offset 1 is a status byte with three parts: an active-low pending flag, a FIFO-full flag and the type code. A write at offset 2 is queued like any other write. In the same cycle it also updates two registered serial-memory lines: bit 1 drives the data line and bit 0 drives the clock line.

Top module: `host_mailbox`

## Requirements
- R1: After reset, `host_irq_n`=1, `ctl_empty`=1, `host_drop`=0, `prom_sda`=`prom_scl`=1, and a read of offset 1 returns 0x80.
- R2: A host write at any offset 0..15 stores {offset, byte} in the FIFO while it is not full. Entries leave in write order. `ctl_off`/`ctl_data` show the oldest entry whenever `ctl_empty`=0. A `ctl_pop` removes that entry at the clock edge.
- R3: After 16 entries the FIFO is full and status bit 6 reads 1. A host write made while full, with no pop in the same cycle, is discarded: the FIFO contents do not change and `host_drop` is 1 in the following cycle only.
- R4: A host write made while full, in the same cycle as a pop, is accepted.
- R5: `ctl_post` loads the data byte returned at offset 0 and the type code returned in status bits 5..3. From the next cycle `host_irq_n`=0 and status bit 7 reads 0. Status bits 2..0 always read 0.
- R6: A host read of offset 0 clears the pending state, so from the next cycle `host_irq_n`=1 and status bit 7 reads 1. A read of offset 1 leaves the pending state unchanged.
- R7: When a post and a host read of offset 0 happen in the same cycle, the post wins and the data stays pending.
- R8: A host write at offset 2 sets `prom_sda` to bit 1 and `prom_scl` to bit 0 from the next cycle, full FIFO or not.
- R9: Host reads of offsets 2..15 return 0.
- R10: A `ctl_pop` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effect at clock edge) |
| host_addr | input | 4 | Window offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| host_irq_n | output | 1 | Active-low data-pending interrupt |
| host_drop | output | 1 | One-cycle pulse after a discarded write |
| prom_sda | output | 1 | Serial-memory data line |
| prom_scl | output | 1 | Serial-memory clock line |
| ctl_pop | input | 1 | Controller removes FIFO head |
| ctl_empty | output | 1 | FIFO empty |
| ctl_off | output | 4 | Offset of FIFO head |
| ctl_data | output | 8 | Byte of FIFO head |
| ctl_post | input | 1 | Controller posts a mailbox byte |
| ctl_post_data | input | 8 | Byte to post |
| ctl_post_type | input | 3 | Type code to post |

## Verification
Two pairs of events can land in the same cycle. The first pair is a host write into a full FIFO and a controller pop. The second pair is a controller post and a host read of the data register. Random phases are biased toward writes, so the FIFO sits at full while pops arrive, and toward reads and posts, so the two mailbox events collide. Directed cycles also force each collision on purpose. A bench model judges every cycle: it applies the pop before the push and gives the post priority over the clear, then compares the FIFO head, the status byte, the interrupt and the drop pulse.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int WIN_BYTES = 16;
    localparam int OFF_W     = $clog2(WIN_BYTES);
    localparam int DATA_W    = 8;
    localparam int TYPE_W    = 3;
    localparam int PAD_W     = DATA_W - 2 - TYPE_W;

    localparam logic [OFF_W-1:0] OFF_MBOX = OFF_W'(0);
    localparam logic [OFF_W-1:0] OFF_STAT = OFF_W'(1);
    localparam logic [OFF_W-1:0] OFF_PROM = OFF_W'(2);

    typedef struct packed {
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] data;
    } mbx_entry_t;

    typedef struct packed {
        logic              pending;
        logic [DATA_W-1:0] data;
        logic [TYPE_W-1:0] kind;
    } mbox_t;

    function automatic logic [DATA_W-1:0] pack_status(input logic pending,
                                                      input logic full,
                                                      input logic [TYPE_W-1:0] kind);
        return {~pending, full, kind, {PAD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
    import mbx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  mbx_entry_t push_entry,
    input  logic       pop,
    output mbx_entry_t head,
    output logic       empty,
    output logic       full,
    output logic       dropped
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    mbx_entry_t       store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             pop_ok, push_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign head    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            dropped <= 1'b0;
        end else begin
            dropped <= push && !push_ok;
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (push_ok && !pop_ok) begin
                count <= count + 1'b1;
            end else if (pop_ok && !push_ok) begin
                count <= count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            store[wr_ptr] <= push_entry;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (dropped && full));
    assert_pop_empty_R10: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);
    assert_pop_full_push_R4: assert property (@(posedge clk) disable iff (rst)
        (push && pop && full) |=> (full && !dropped));
endmodule

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [OFF_W-1:0]  host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              fifo_full,
    input  logic              post,
    input  logic [DATA_W-1:0] post_data,
    input  logic [TYPE_W-1:0] post_type,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq_n,
    output logic              sda,
    output logic              scl
);
    mbox_t mbox;
    logic  rd_mbox;

    assign rd_mbox = host_rd && (host_addr == OFF_MBOX);
    assign irq_n   = ~mbox.pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            mbox <= '0;
            sda  <= 1'b1;
            scl  <= 1'b1;
        end else begin
            if (post) begin
                mbox.pending <= 1'b1;
                mbox.data    <= post_data;
                mbox.kind    <= post_type;
            end else if (rd_mbox) begin
                mbox.pending <= 1'b0;
            end
            if (host_wr && host_addr == OFF_PROM) begin
                sda <= host_wdata[1];
                scl <= host_wdata[0];
            end
        end
    end

    always_comb begin
        unique case (host_addr)
            OFF_MBOX: host_rdata = mbox.data;
            OFF_STAT: host_rdata = pack_status(mbox.pending, fifo_full, mbox.kind);
            default:  host_rdata = '0;
        endcase
    end

    assert_irq_set_R5: assert property (@(posedge clk) disable iff (rst)
        post |=> !irq_n);
    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_mbox && !post) |=> irq_n);
    assert_stat_read_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (!post && !rd_mbox) |=> $stable(irq_n));
    assert_pad_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (host_addr == OFF_STAT) |-> (host_rdata[PAD_W-1:0] == '0));
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
    import mbx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [OFF_W-1:0]  host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_irq_n,
    output logic              host_drop,
    output logic              prom_sda,
    output logic              prom_scl,
    input  logic              ctl_pop,
    output logic              ctl_empty,
    output logic [OFF_W-1:0]  ctl_off,
    output logic [DATA_W-1:0] ctl_data,
    input  logic              ctl_post,
    input  logic [DATA_W-1:0] ctl_post_data,
    input  logic [TYPE_W-1:0] ctl_post_type
);
    mbx_entry_t in_entry, head;
    logic       full;

    assign in_entry = '{off: host_addr, data: host_wdata};
    assign ctl_off  = head.off;
    assign ctl_data = head.data;

    mbx_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (host_wr),
        .push_entry (in_entry),
        .pop        (ctl_pop),
        .head       (head),
        .empty      (ctl_empty),
        .full       (full),
        .dropped    (host_drop)
    );

    mbx_host_regs i_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .fifo_full  (full),
        .post       (ctl_post),
        .post_data  (ctl_post_data),
        .post_type  (ctl_post_type),
        .host_rdata (host_rdata),
        .irq_n      (host_irq_n),
        .sda        (prom_sda),
        .scl        (prom_scl)
    );
endmodule

// File: tb/test_host_mailbox.sv
module test_host_mailbox;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 0, host_rd = 0, ctl_pop = 0, ctl_post = 0;
    logic [3:0] host_addr = 0;
    logic [7:0] host_wdata = 0, ctl_post_data = 0;
    logic [2:0] ctl_post_type = 0;
    logic [7:0] host_rdata, ctl_data;
    logic [3:0] ctl_off;
    logic       host_irq_n, host_drop, prom_sda, prom_scl, ctl_empty;

    int checks = 0, failures = 0;

    int         q[$];
    logic       m_pend = 0, m_drop = 0, m_sda = 1, m_scl = 1;
    logic [7:0] m_data = 0;
    logic [2:0] m_type = 0;

    always #2.5 clk = ~clk;

    host_mailbox i_host_mailbox (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_irq_n(host_irq_n), .host_drop(host_drop), .prom_sda(prom_sda),
        .prom_scl(prom_scl), .ctl_pop(ctl_pop), .ctl_empty(ctl_empty),
        .ctl_off(ctl_off), .ctl_data(ctl_data), .ctl_post(ctl_post),
        .ctl_post_data(ctl_post_data), .ctl_post_type(ctl_post_type)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        if (a == 4'd0) return m_data;
        if (a == 4'd1) return {~m_pend, (q.size() == DEPTH), m_type, 3'b000};
        return 8'h00;
    endfunction

    // One cycle: drive after negedge, check, update model for the coming edge.
    task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                        input logic [7:0] wd, input logic pop, input logic post,
                        input logic [7:0] pd, input logic [2:0] pt);
        logic pop_eff, push_ok;
        @(negedge clk);
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
        ctl_pop = pop; ctl_post = post; ctl_post_data = pd; ctl_post_type = pt;
        #1;
        chk("R5/R6 irq_n", host_irq_n, !m_pend);
        chk("R2/R10 empty", ctl_empty, q.size() == 0);
        if (q.size() != 0) chk("R2 head", {ctl_off, ctl_data}, q[0]);
        chk("R3 drop pulse", host_drop, m_drop);
        chk("R8 sda/scl", {prom_sda, prom_scl}, {m_sda, m_scl});
        if (rd) chk((a > 4'd1) ? "R9 read" : "R5/R3 read", host_rdata, exp_read(a));
        pop_eff = pop && q.size() != 0;
        push_ok = wr && (q.size() < DEPTH || pop_eff);
        m_drop  = wr && !push_ok;
        if (pop_eff) void'(q.pop_front());
        if (push_ok) q.push_back({a, wd});
        if (post) begin m_pend = 1; m_data = pd; m_type = pt; end
        else if (rd && a == 4'd0) m_pend = 0;
        if (wr && a == 4'd2) begin m_sda = wd[1]; m_scl = wd[0]; end
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(5 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        // R1: reset state
        #1;
        chk("R1 irq_n", host_irq_n, 1);
        chk("R1 empty", ctl_empty, 1);
        chk("R1 drop", host_drop, 0);
        chk("R1 sda/scl", {prom_sda, prom_scl}, 2'b11);
        step(0, 1, 4'd1, 0, 0, 0, 0, 0);
        chk("R1 status", host_rdata, 8'h80);

        // R10: pop on empty
        step(0, 0, 0, 0, 1, 0, 0, 0);
        idle();

        // R2/R3: fill all offsets then overflow
        for (int i = 0; i < DEPTH; i++) step(1, 0, 4'(i), 8'(8'hA0 + i), 0, 0, 0, 0);
        step(0, 1, 4'd1, 0, 0, 0, 0, 0);
        chk("R3 full bit", host_rdata[6], 1);
        step(1, 0, 4'd5, 8'h55, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        // R4: write while full with pop
        step(1, 0, 4'd9, 8'h99, 1, 0, 0, 0);
        idle();

        // R8: offset 2 write while full also drives lines
        step(1, 0, 4'd2, 8'h01, 0, 0, 0, 0);
        idle();

        // R5/R6/R7: post, status read, collision, clear
        step(0, 0, 0, 0, 0, 1, 8'h3C, 3'd5);
        step(0, 1, 4'd1, 0, 0, 0, 0, 0);
        step(0, 1, 4'd0, 0, 0, 1, 8'hC3, 3'd2);
        step(0, 1, 4'd0, 0, 0, 0, 0, 0);
        step(0, 1, 4'd1, 0, 0, 0, 0, 0);
        for (int a = 2; a < 16; a++) step(0, 1, 4'(a), 0, 0, 0, 0, 0);

        // Random phases: write-heavy, then pop-heavy, then mailbox-heavy
        for (int ph = 0; ph < 3; ph++) begin
            for (int n = 0; n < 1500; n++) begin
                logic       wr, rd, pop, post;
                logic [3:0] a;
                wr   = ($urandom % 100) < (ph == 0 ? 70 : 30);
                rd   = !wr && (($urandom % 100) < 60);
                pop  = ($urandom % 100) < (ph == 1 ? 70 : 25);
                post = ($urandom % 100) < (ph == 2 ? 40 : 10);
                a    = rd ? 4'($urandom % 4) : 4'($urandom);
                step(wr, rd, a, 8'($urandom), pop, post, 8'($urandom), 3'($urandom));
            end
        end
        idle();
        finish_run();
    end
endmodule